// File: doc/BRIEF.md
# Privileged Cache Writeback-Invalidate Sequencer

This block holds a small direct-mapped data cache model and runs a whole-cache flush on request. A caller raises `start` together with its privilege level. If that level is not zero, the request is refused with a one-cycle general-protection fault and nothing in the cache changes.

A privileged request walks the lines from index 0 upward. Each line that is both valid and modified is sent to memory through a valid/acknowledge write port, and the walk waits for the acknowledge before it moves on. Every line, dirty or clean, is invalidated as the walk leaves it. After the last line, one pulse tells the outer cache levels to clean and invalidate themselves. Completion is reported in the same cycle, without waiting for those outer levels.

The operation is serializing. While `busy` is high, new flush requests and cache accesses are dropped. The cache access port loads lines (clean fill or modified store) and probes them. A separate translation-valid vector sits beside the cache, and a flush never changes it.

Top module: `wbinv_seq_top`

## Requirements
- R1: After reset, `busy`, `done`, `gp_fault`, `ext_flush_req` and `mem_wr_valid` are 0. Every cache line is invalid, and `tlb_valid` is all zero.
- R2: A `start` taken while idle with `cpl` not equal to 0 raises `gp_fault` for exactly the next cycle. In that case `busy` stays 0, no memory write is issued, and neither the cache lines nor `tlb_valid` change.
- R3: A `start` taken while idle with `cpl` equal to 0 sets `busy` from the next cycle. `busy` stays high until the cycle in which `done` pulses, and is low in that cycle.
- R4: Every line that is valid and dirty is written back with `mem_wr_addr` = {stored tag, line index} and `mem_wr_data` = the line's data. Write-backs go in ascending index order, one at a time, each finishing with `mem_wr_ack` before the next line is examined.
- R5: Clean valid lines and invalid lines cause no memory write. A flush of a cache with no dirty lines issues no write at all.
- R6: When `done` pulses, every line is invalid: a later probe of any index misses.
- R7: `ext_flush_req` pulses for exactly one cycle per privileged operation, in the same cycle as the one-cycle `done` pulse, after the last line has been invalidated.
- R8: A flush leaves `tlb_valid` unchanged. Outside a flush, `tlb_set_en` sets bit `tlb_set_idx` of `tlb_valid` in the next cycle.
- R9: While `busy` is high, `start` and `acc_en` are ignored: no fault, no second operation, and no change to any line.
- R10: While idle, `acc_en` with `acc_we`=1 writes tag, data and the dirty flag `acc_dirty` into line `acc_idx` and marks it valid. `acc_en` with `acc_we`=0 probes the line. In the next cycle, `rd_hit` is 1 when the line is valid and its tag equals `acc_tag`, `rd_dirty` is the line's dirty bit, and `rd_data` is its data.
- R11: Once `mem_wr_valid` rises, it stays high with stable `mem_wr_addr` and `mem_wr_data` until the cycle in which `mem_wr_ack` is seen, and drops in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Flush request |
| cpl | input | 2 | Privilege level of the requester (0 = most privileged) |
| busy | output | 1 | Flush in progress; stalls requests and accesses |
| done | output | 1 | One-cycle completion pulse |
| gp_fault | output | 1 | One-cycle privilege fault pulse |
| acc_en | input | 1 | Cache access strobe |
| acc_we | input | 1 | 1 = write line, 0 = probe line |
| acc_dirty | input | 1 | Dirty flag stored on a write |
| acc_idx | input | IDX_W | Line index of the access |
| acc_tag | input | TAG_W | Tag written or compared |
| acc_data | input | DATA_W | Line data written |
| rd_hit | output | 1 | Probe result: valid and tag match |
| rd_dirty | output | 1 | Probe result: dirty bit of the line |
| rd_data | output | DATA_W | Probe result: line data |
| tlb_set_en | input | 1 | Set one translation-valid bit |
| tlb_set_idx | input | TLB_W | Bit to set |
| tlb_valid | output | TLB_N | Translation-valid vector |
| mem_wr_valid | output | 1 | Write-back request |
| mem_wr_addr | output | TAG_W+IDX_W | Line address {tag, index} |
| mem_wr_data | output | DATA_W | Line data |
| mem_wr_ack | input | 1 | Memory accepted the write |
| ext_flush_req | output | 1 | One-cycle request to flush outer caches |

## Verification
The assertions assume that `mem_wr_ack` is raised only while `mem_wr_valid` is high. They also assume that `start` and a cache access are never given in the same idle cycle, because the access is then dropped in favour of the request. The bench's memory responder acks only an outstanding write, two cycles after it appears, and drops the ack once it has been taken. The directed sequences never overlap a request with an access while idle. Accesses and requests made during a flush are deliberate, and are checked at the ports for having no effect.

// File: rtl/wbinv_seq_pkg.sv
package wbinv_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SCAN = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/wbinv_line_store.sv
module wbinv_line_store #(
  parameter int LINES  = 8,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_dirty,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic [LINES-1:0]  valid_vec
);
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];
  logic [LINES-1:0]  valid_q, dirty_q;

  // Tag and data arrays carry no reset so they can map to RAM.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  // State bits are flops so that a single line can be cleared per cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (clr_en) begin
      valid_q[clr_idx] <= 1'b0;
      dirty_q[clr_idx] <= 1'b0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  assign rd_valid  = valid_q[rd_idx];
  assign rd_dirty  = dirty_q[rd_idx];
  assign rd_tag    = tag_mem[rd_idx];
  assign rd_data   = data_mem[rd_idx];
  assign valid_vec = valid_q;

  // R10: a write and a clear never arrive in the same cycle
  assert_no_wr_clr_clash_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && clr_en));
endmodule

// File: rtl/wbinv_walker.sv
module wbinv_walker
  import wbinv_seq_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        cpl,
  input  logic              line_valid,
  input  logic              line_dirty,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic [IDX_W-1:0]  walk_idx,
  output logic              clr_en,
  output logic              busy,
  output logic              done,
  output logic              gp_fault,
  output logic              ext_flush_req,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  seq_state_e st_q;
  logic       step;

  // A line is finished when it needs no write or its write was acknowledged.
  always_comb begin
    step = 1'b0;
    if (st_q == SEQ_SCAN) step = !(line_valid && line_dirty);
    if (st_q == SEQ_WAIT) step = mem_wr_ack;
  end
  assign clr_en = step;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= SEQ_IDLE;
      walk_idx      <= '0;
      busy          <= 1'b0;
      done          <= 1'b0;
      gp_fault      <= 1'b0;
      ext_flush_req <= 1'b0;
      mem_wr_valid  <= 1'b0;
      mem_wr_addr   <= '0;
      mem_wr_data   <= '0;
    end else begin
      done          <= 1'b0;
      gp_fault      <= 1'b0;
      ext_flush_req <= 1'b0;
      case (st_q)
        SEQ_IDLE: if (start) begin
          if (cpl != 2'd0) begin
            gp_fault <= 1'b1;
          end else begin
            busy     <= 1'b1;
            walk_idx <= '0;
            st_q     <= SEQ_SCAN;
          end
        end
        SEQ_SCAN: if (line_valid && line_dirty) begin
          mem_wr_valid <= 1'b1;
          mem_wr_addr  <= {line_tag, walk_idx};
          mem_wr_data  <= line_data;
          st_q         <= SEQ_WAIT;
        end
        SEQ_WAIT: if (mem_wr_ack) mem_wr_valid <= 1'b0;
        default: st_q <= SEQ_IDLE;
      endcase
      if (step) begin
        if (walk_idx == LAST_IDX) begin
          st_q          <= SEQ_IDLE;
          busy          <= 1'b0;
          done          <= 1'b1;
          ext_flush_req <= 1'b1;
        end else begin
          walk_idx <= walk_idx + 1'b1;
          st_q     <= SEQ_SCAN;
        end
      end
    end
  end

  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ack) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
  assert_ext_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    ext_flush_req |=> !ext_flush_req);
  assert_fault_cause_R2: assert property (@(posedge clk) disable iff (rst)
    gp_fault |-> ($past(start) && $past(cpl) != 2'd0 && !busy));
  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) && $past(cpl) == 2'd0));
endmodule

// File: rtl/wbinv_seq_top.sv
module wbinv_seq_top #(
  parameter int LINES  = 8,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  parameter int TLB_N  = 8,
  localparam int IDX_W  = $clog2(LINES),
  localparam int ADDR_W = TAG_W + IDX_W,
  localparam int TLB_W  = $clog2(TLB_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        cpl,
  output logic              busy,
  output logic              done,
  output logic              gp_fault,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic              acc_dirty,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [TAG_W-1:0]  acc_tag,
  input  logic [DATA_W-1:0] acc_data,
  output logic              rd_hit,
  output logic              rd_dirty,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tlb_set_en,
  input  logic [TLB_W-1:0]  tlb_set_idx,
  output logic [TLB_N-1:0]  tlb_valid,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack,
  output logic              ext_flush_req
);
  logic              acc_ok, wr_en, clr_en;
  logic [IDX_W-1:0]  walk_idx, rd_idx;
  logic              ln_valid, ln_dirty;
  logic [TAG_W-1:0]  ln_tag;
  logic [DATA_W-1:0] ln_data;
  logic [LINES-1:0]  valid_vec;

  // Serializing: accesses are only taken while idle and no request is pending.
  assign acc_ok = acc_en && !busy && !start;
  assign wr_en  = acc_ok && acc_we;
  assign rd_idx = busy ? walk_idx : acc_idx;

  wbinv_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(acc_idx), .wr_tag(acc_tag), .wr_data(acc_data), .wr_dirty(acc_dirty),
    .clr_en(clr_en), .clr_idx(walk_idx), .rd_idx(rd_idx),
    .rd_valid(ln_valid), .rd_dirty(ln_dirty), .rd_tag(ln_tag), .rd_data(ln_data),
    .valid_vec(valid_vec)
  );

  wbinv_walker #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) walker_i (
    .clk(clk), .rst(rst), .start(start), .cpl(cpl),
    .line_valid(ln_valid), .line_dirty(ln_dirty), .line_tag(ln_tag), .line_data(ln_data),
    .walk_idx(walk_idx), .clr_en(clr_en),
    .busy(busy), .done(done), .gp_fault(gp_fault), .ext_flush_req(ext_flush_req),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hit   <= 1'b0;
      rd_dirty <= 1'b0;
      rd_data  <= '0;
    end else if (acc_ok && !acc_we) begin
      rd_hit   <= ln_valid && (ln_tag == acc_tag);
      rd_dirty <= ln_dirty;
      rd_data  <= ln_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tlb_valid <= '0;
    else if (tlb_set_en) tlb_valid[tlb_set_idx] <= 1'b1;
  end

  assert_all_invalid_at_done_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (valid_vec == '0));
  assert_done_with_ext_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> ext_flush_req);
  assert_tlb_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(tlb_set_en)) |-> $stable(tlb_valid));
endmodule

// File: tb/wbinv_seq_top_tb_top.sv
`timescale 1ns/1ps
module wbinv_seq_top_tb_top;
  localparam int LINES = 8, TAG_W = 8, DATA_W = 32, TLB_N = 8;
  localparam int IDX_W = $clog2(LINES), ADDR_W = TAG_W + IDX_W, TLB_W = $clog2(TLB_N);

  logic clk = 0, rst = 1, start = 0, acc_en = 0, acc_we = 0, acc_dirty = 0;
  logic [1:0] cpl = 0;
  logic [IDX_W-1:0] acc_idx = 0;
  logic [TAG_W-1:0] acc_tag = 0;
  logic [DATA_W-1:0] acc_data = 0;
  logic tlb_set_en = 0, mem_wr_ack = 0;
  logic [TLB_W-1:0] tlb_set_idx = 0;
  logic busy, done, gp_fault, rd_hit, rd_dirty, mem_wr_valid, ext_flush_req;
  logic [DATA_W-1:0] rd_data, mem_wr_data;
  logic [TLB_N-1:0] tlb_valid;
  logic [ADDR_W-1:0] mem_wr_addr;

  int checks = 0, errors = 0;
  int wr_cnt = 0, done_cnt = 0, ext_cnt = 0, gp_cnt = 0, hold_err = 0, pair_err = 0;
  logic [ADDR_W-1:0] log_addr [8];
  logic [DATA_W-1:0] log_data [8];

  always #4 clk = ~clk;

  wbinv_seq_top #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .TLB_N(TLB_N)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cpl(cpl), .busy(busy), .done(done), .gp_fault(gp_fault),
    .acc_en(acc_en), .acc_we(acc_we), .acc_dirty(acc_dirty), .acc_idx(acc_idx), .acc_tag(acc_tag),
    .acc_data(acc_data), .rd_hit(rd_hit), .rd_dirty(rd_dirty), .rd_data(rd_data),
    .tlb_set_en(tlb_set_en), .tlb_set_idx(tlb_set_idx), .tlb_valid(tlb_valid),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack), .ext_flush_req(ext_flush_req)
  );

  // Probe table: {idx, tag, exp_hit, exp_dirty, exp_data} for the filled cache.
  localparam logic [44:0] PROBE [8] = '{
    {3'd0, 8'h11, 1'b1, 1'b1, 32'hA0},
    {3'd0, 8'h12, 1'b0, 1'b1, 32'h0},
    {3'd1, 8'h22, 1'b1, 1'b0, 32'hA1},
    {3'd2, 8'h00, 1'b0, 1'b0, 32'h0},
    {3'd3, 8'h33, 1'b1, 1'b1, 32'hA3},
    {3'd4, 8'h44, 1'b0, 1'b0, 32'h0},
    {3'd7, 8'h77, 1'b1, 1'b1, 32'hA7},
    {3'd7, 8'h78, 1'b0, 1'b1, 32'h0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory responder and event monitor, all on the falling edge.
  initial begin
    int wait_cnt = 0;
    logic [ADDR_W-1:0] first_addr = '0;
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
      if (ext_flush_req) ext_cnt++;
      if (gp_fault) gp_cnt++;
      if (done != ext_flush_req) pair_err++;
      if (mem_wr_valid && !mem_wr_ack) begin
        wait_cnt++;
        if (wait_cnt == 1) first_addr = mem_wr_addr;
        if (wait_cnt == 2) begin
          if (mem_wr_addr != first_addr) hold_err++;
          if (wr_cnt < 8) begin
            log_addr[wr_cnt] = mem_wr_addr;
            log_data[wr_cnt] = mem_wr_data;
          end
          wr_cnt++;
          mem_wr_ack = 1;
          wait_cnt = 0;
        end
      end else begin
        mem_wr_ack = 0;
      end
    end
  end

  task automatic cache_write(input int idx, input int tag, input int data, input bit dirty);
    @(negedge clk);
    acc_en = 1; acc_we = 1; acc_idx = IDX_W'(idx); acc_tag = TAG_W'(tag);
    acc_data = DATA_W'(data); acc_dirty = dirty;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
  endtask

  task automatic probe(input int idx, input int tag);
    @(negedge clk);
    acc_en = 1; acc_we = 0; acc_idx = IDX_W'(idx); acc_tag = TAG_W'(tag);
    @(negedge clk);
    acc_en = 0;
  endtask

  task automatic walk_table(input bit after_flush, input string req);
    for (int i = 0; i < 8; i++) begin
      logic [44:0] e = PROBE[i];
      probe(int'(e[44:42]), int'(e[41:34]));
      if (after_flush) check(rd_hit == 1'b0, req, rd_hit, 0);
      else begin
        check(rd_hit == e[33], req, rd_hit, e[33]);
        if (e[33]) check(rd_dirty == e[32] && rd_data == e[31:0], req, {rd_dirty, rd_data}, {e[32], e[31:0]});
      end
    end
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    int wr0, gp0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check({busy, done, gp_fault, ext_flush_req, mem_wr_valid} == 5'b0, "R1", {busy, done, gp_fault, ext_flush_req, mem_wr_valid}, 0);
    check(tlb_valid == '0, "R1", tlb_valid, 0);
    probe(0, 0);
    check(rd_hit == 1'b0, "R1", rd_hit, 0);

    // Fill: dirty 0,3,7; clean 1; others invalid. R10
    cache_write(0, 'h11, 'hA0, 1);
    cache_write(1, 'h22, 'hA1, 0);
    cache_write(3, 'h33, 'hA3, 1);
    cache_write(7, 'h77, 'hA7, 1);
    @(negedge clk); tlb_set_en = 1; tlb_set_idx = 1;
    @(negedge clk); tlb_set_idx = 5;
    @(negedge clk); tlb_set_en = 0;
    check(tlb_valid == 8'h22, "R8", tlb_valid, 8'h22);
    walk_table(0, "R10");

    // R2 refused request
    @(negedge clk); start = 1; cpl = 2'd3;
    @(negedge clk); start = 0; cpl = 2'd0;
    check(gp_fault == 1'b1 && busy == 1'b0, "R2", {gp_fault, busy}, 2'b10);
    @(negedge clk);
    check(gp_fault == 1'b0 && mem_wr_valid == 1'b0, "R2", {gp_fault, mem_wr_valid}, 0);
    walk_table(0, "R2");
    check(tlb_valid == 8'h22 && wr_cnt == 0, "R2", {tlb_valid, 8'(wr_cnt)}, 16'h2200);

    // Privileged flush, with stalled access and request during busy
    gp0 = gp_cnt;
    @(negedge clk); start = 1; cpl = 2'd0;
    @(negedge clk); start = 0;
    check(busy == 1'b1, "R3", busy, 1);
    start = 1; cpl = 2'd2; acc_en = 1; acc_we = 1; acc_idx = 2; acc_tag = 8'h5A; acc_dirty = 1; acc_data = 32'h55;
    @(negedge clk); start = 0; cpl = 0; acc_en = 0; acc_we = 0;
    check(busy == 1'b1, "R3", busy, 1);
    wait_done(cyc);
    check(done == 1'b1 && busy == 1'b0, "R3", {done, busy}, 2'b10);
    check(ext_flush_req == 1'b1, "R7", ext_flush_req, 1);
    @(negedge clk);
    check(done == 1'b0 && ext_flush_req == 1'b0, "R7", {done, ext_flush_req}, 0);
    check(wr_cnt == 3, "R5", wr_cnt, 3);
    check(log_addr[0] == {8'h11, 3'd0} && log_data[0] == 32'hA0, "R4", {log_addr[0], log_data[0]}, {8'h11, 3'd0, 32'hA0});
    check(log_addr[1] == {8'h33, 3'd3} && log_data[1] == 32'hA3, "R4", {log_addr[1], log_data[1]}, {8'h33, 3'd3, 32'hA3});
    check(log_addr[2] == {8'h77, 3'd7} && log_data[2] == 32'hA7, "R4", {log_addr[2], log_data[2]}, {8'h77, 3'd7, 32'hA7});
    check(hold_err == 0, "R11", hold_err, 0);
    check(gp_cnt == gp0, "R9", gp_cnt, gp0);
    check(done_cnt == 1 && ext_cnt == 1 && pair_err == 0, "R7", {8'(done_cnt), 8'(ext_cnt), 8'(pair_err)}, 24'h010100);
    check(tlb_valid == 8'h22, "R8", tlb_valid, 8'h22);
    probe(2, 'h5A);
    check(rd_hit == 1'b0, "R9", rd_hit, 0);
    walk_table(1, "R6");

    // Second flush on an empty cache: no writes, one more pulse pair. R5
    wr0 = wr_cnt;
    @(negedge clk); start = 1; cpl = 2'd0;
    @(negedge clk); start = 0;
    wait_done(cyc);
    check(done == 1'b1 && cyc <= LINES + 1, "R5", cyc, LINES + 1);
    repeat (2) @(negedge clk);
    check(wr_cnt == wr0, "R5", wr_cnt, wr0);
    check(done_cnt == 2 && ext_cnt == 2, "R7", {8'(done_cnt), 8'(ext_cnt)}, 16'h0202);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule